// File: doc/BRIEF.md
# Pad pull-resistor sequencer

This block keeps the pull-resistor setting of every pad of a multi-bank general-purpose pin array: no pull, pull-down or pull-up, two bits per pin. Software does not write these settings pin by pin. It uses a two-step handshake instead. First it writes the wanted pull code into one shared mode register. It then writes a per-pin mask into the clock register of the bank that holds the pins. Each pin whose clock bit goes from 0 to 1 takes the pending code. Every other pin keeps the setting it already has. The usual closing steps are to write the mode back to 0 and then to write the clock register back to 0.

The mode code must be settled before the clock pulse. A write that raises clock bits is honoured only if the mode register has kept its value for at least `SETUP_CYC` cycles. If the mode is younger than that, no pin changes and a sticky error flag goes high. Only reset clears the flag. The per-pin settings go straight out to the pad ring as a flat vector. Both registers read back through a combinational read port.

Top module: `pud_seq`

## Requirements
- R1: After reset every pin reports no pull (00), the error flag is 0, and the mode register and every clock register read back 0.
- R2: The mode register sits at byte address 0x94 and keeps bits [1:0] of the written word, which it returns on read. Code 0 selects no pull, 1 pull-down and 2 pull-up. Pin p reports its setting on output bits [2p+1:2p], encoded 00 none, 01 down, 10 up.
- R3: Clock register b sits at 0x98 + 4*b, and its bit i belongs to pin 32*b + i. Each clock register returns its last written value, and bits that map to pins beyond NUM_PINS always read 0.
- R4: A write that takes a pin's clock bit from 0 to 1 while the mode is settled loads the decoded mode into that pin. The new setting is visible from the cycle after the write, and no pin without a rising clock bit changes.
- R5: Mode code 3 is reserved, and a pin clocked with it ends up at no pull (00).
- R6: The mode counts as settled once SETUP_CYC or more clock cycles have passed since the last write that changed its value, or since reset was released. A write of the value already held does not restart that count. A write that raises clock bits before the mode is settled changes no pin and sets the error flag.
- R7: Once set, the error flag stays at 1 until reset, even across later correct sequences.
- R8: Clock bits that are already 1 when rewritten capture nothing. Changing or clearing the mode while clock bits are high leaves every pin setting as it is.
- R9: Writes to any other address change no register or pin, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | 32 | Read data |
| pull_o | output | 2*NUM_PINS | Per-pin pull setting, two bits per pin |
| err_o | output | 1 | Sticky setup-violation flag |

## Verification
The bench builds the block with `SETUP_CYC` = 8 and `NUM_PINS` = 54. With the short setup window, a clock write one cycle before the mode is settled and one exactly on the threshold both fit in a few cycles. Each can be run many times in a long random phase that mixes mode changes, same-value rewrites and clock pulses. The 54-pin count leaves the second bank only partly populated, so the readback of bits for pins that do not exist and the ignoring of writes to them are both exercised.

// File: rtl/pud_pkg.sv
package pud_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2
  } pull_e;

  // Reserved code 3 collapses to no pull.
  function automatic pull_e mode_to_pull(input logic [1:0] code);
    case (code)
      2'd1:    return PULL_DOWN;
      2'd2:    return PULL_UP;
      default: return PULL_NONE;
    endcase
  endfunction

  function automatic int num_banks(input int npins);
    return (npins + WORD_W - 1) / WORD_W;
  endfunction

  function automatic int bank_addr(input int base, input int bank);
    return base + 4 * bank;
  endfunction

  // Bits of a bank word that map to existing pins.
  function automatic logic [WORD_W-1:0] bank_live_bits(input int bank, input int npins);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) begin
      m[i] = ((bank * WORD_W + i) < npins);
    end
    return m;
  endfunction

endpackage

// File: rtl/pud_regfile.sv
module pud_regfile
  import pud_pkg::*;
#(
  parameter int NUM_PINS  = 54,
  parameter int ADDR_W    = 8,
  parameter int MODE_ADDR = 'h94,
  parameter int CLK_BASE  = 'h98
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [WORD_W-1:0]    rd_data,
  output logic [1:0]           mode_q,
  output logic                 mode_wr_evt,
  output logic                 mode_chg_evt,
  output logic [NUM_PINS-1:0]  rise_vec
);

  localparam int NBANK = num_banks(NUM_PINS);
  localparam int PAD_W = NBANK * WORD_W;

  logic [NBANK-1:0]    bank_hit;
  logic [NUM_PINS-1:0] clk_bits;
  logic [PAD_W-1:0]    pad_bits;

  assign mode_wr_evt  = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
  assign mode_chg_evt = mode_wr_evt && (wr_data[1:0] != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
    end else if (mode_wr_evt) begin
      mode_q <= wr_data[1:0];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_hit[b] = wr_en && (wr_addr == ADDR_W'(bank_addr(CLK_BASE, b)));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int PB = p / WORD_W;
    localparam int PI = p % WORD_W;
    logic bit_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (bank_hit[PB]) begin
        bit_q <= wr_data[PI];
      end
    end

    assign clk_bits[p] = bit_q;
    assign rise_vec[p] = bank_hit[PB] & wr_data[PI] & ~bit_q;
  end

  always_comb begin
    pad_bits = '0;
    pad_bits[NUM_PINS-1:0] = clk_bits;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(MODE_ADDR)) begin
      rd_data = WORD_W'(mode_q);
    end
    for (int b = 0; b < NBANK; b++) begin
      if (rd_addr == ADDR_W'(bank_addr(CLK_BASE, b))) begin
        rd_data = pad_bits[b*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/pud_settle_timer.sv
module pud_settle_timer #(
  parameter int SETUP_CYC = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_chg_evt,
  output logic settle_ready
);

  localparam int CW = $clog2(SETUP_CYC + 1);

  logic [CW-1:0] age_q;

  assign settle_ready = (age_q >= CW'(SETUP_CYC));

  // Saturating age of the current mode value.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (mode_chg_evt) begin
      age_q <= CW'(1);
    end else if (!settle_ready) begin
      age_q <= age_q + 1'b1;
    end
  end

endmodule

// File: rtl/pud_pin_state.sv
module pud_pin_state
  import pud_pkg::*;
#(
  parameter int NUM_PINS = 54
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   rise_vec,
  input  logic                  settle_ready,
  input  logic [1:0]            mode_q,
  output logic [2*NUM_PINS-1:0] pull_o,
  output logic                  err_o
);

  pull_e pend_code;
  logic  any_rise;

  assign pend_code = mode_to_pull(mode_q);
  assign any_rise  = |rise_vec;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pull_e st_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= PULL_NONE;
      end else if (rise_vec[p] && settle_ready) begin
        st_q <= pend_code;
      end
    end

    assign pull_o[2*p +: 2] = st_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_o <= 1'b0;
    end else if (any_rise && !settle_ready) begin
      err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/pud_seq.sv
module pud_seq
  import pud_pkg::*;
#(
  parameter int NUM_PINS  = 54,
  parameter int SETUP_CYC = 150,
  parameter int ADDR_W    = 8,
  parameter int MODE_ADDR = 'h94,
  parameter int CLK_BASE  = 'h98
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [31:0]           rd_data,
  output logic [2*NUM_PINS-1:0] pull_o,
  output logic                  err_o
);

  logic [1:0]          mode_q;
  logic                mode_wr_evt;
  logic                mode_chg_evt;
  logic                settle_ready;
  logic [NUM_PINS-1:0] rise_vec;

  pud_regfile #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .MODE_ADDR(MODE_ADDR),
    .CLK_BASE (CLK_BASE)
  ) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .mode_q      (mode_q),
    .mode_wr_evt (mode_wr_evt),
    .mode_chg_evt(mode_chg_evt),
    .rise_vec    (rise_vec)
  );

  pud_settle_timer #(
    .SETUP_CYC(SETUP_CYC)
  ) timer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_chg_evt(mode_chg_evt),
    .settle_ready(settle_ready)
  );

  pud_pin_state #(
    .NUM_PINS(NUM_PINS)
  ) state_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_vec    (rise_vec),
    .settle_ready(settle_ready),
    .mode_q      (mode_q),
    .pull_o      (pull_o),
    .err_o       (err_o)
  );

endmodule

// File: rtl/pud_seq_chk.sv
module pud_seq_chk #(
  parameter int NUM_PINS = 54
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [31:0]           wr_data,
  input logic                  mode_wr_evt,
  input logic [1:0]            mode_q,
  input logic                  settle_ready,
  input logic [NUM_PINS-1:0]   rise_vec,
  input logic [2*NUM_PINS-1:0] pull_o,
  input logic                  err_o
);

  // R2: mode register holds the written code
  a_r2_mode_readback: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_evt |=> (mode_q == $past(wr_data[1:0])));

  // R6: early clock pulse raises the flag
  a_r6_early_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rise_vec) && !settle_ready) |=> err_o);

  // R6: early clock pulse leaves every pin alone
  a_r6_early_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rise_vec) && !settle_ready) |=> $stable(pull_o));

  // R7: flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R8: without a rising clock bit no pin changes
  a_r8_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(|rise_vec) |=> $stable(pull_o));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    // R4: settled capture loads the pending code
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_vec[p] && settle_ready) |=>
        (pull_o[2*p +: 2] == (($past(mode_q) == 2'd3) ? 2'd0 : $past(mode_q))));

    // R5: reserved code never reaches a pad
    a_r5_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
      pull_o[2*p +: 2] != 2'b11);
  end

endmodule

bind pud_seq pud_seq_chk #(
  .NUM_PINS(NUM_PINS)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_data     (wr_data),
  .mode_wr_evt (mode_wr_evt),
  .mode_q      (mode_q),
  .settle_ready(settle_ready),
  .rise_vec    (rise_vec),
  .pull_o      (pull_o),
  .err_o       (err_o)
);

// File: tb/pud_seq_tb_top.sv
`timescale 1ns/1ps
module pud_seq_tb_top;

  localparam int NP = 54;
  localparam int SC = 8;
  localparam logic [7:0] A_MODE = 8'h94;
  localparam logic [7:0] A_CK0  = 8'h98;
  localparam logic [7:0] A_CK1  = 8'h9C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [7:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic [2*NP-1:0] pull_o;
  logic          err_o;

  int n_chk = 0;
  int n_err = 0;
  bit live = 1'b0;
  bit done = 1'b0;
  int rot = 0;

  always #2 clk = ~clk;

  pud_seq #(
    .NUM_PINS (NP),
    .SETUP_CYC(SC),
    .ADDR_W   (8),
    .MODE_ADDR('h94),
    .CLK_BASE ('h98)
  ) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .pull_o (pull_o),
    .err_o  (err_o)
  );

  // ---------------- reference model ----------------
  int        m_pull[NP];
  int        m_mode = 0;
  bit [31:0] m_clk[2];
  int        m_age = 0;
  bit        m_err = 1'b0;

  function automatic bit [31:0] live_bits(int b);
    bit [31:0] v = '0;
    for (int i = 0; i < 32; i++) if (b * 32 + i < NP) v[i] = 1'b1;
    return v;
  endfunction

  always @(posedge clk) begin
    bit        rdy;
    int        nxt;
    bit [31:0] rise;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) m_pull[p] = 0;
      m_mode = 0; m_clk[0] = '0; m_clk[1] = '0; m_age = 0; m_err = 1'b0;
    end else begin
      rdy = (m_age >= SC);
      nxt = (m_age < SC) ? m_age + 1 : m_age;
      if (wr_en) begin
        if (wr_addr == A_MODE) begin
          if (int'(wr_data[1:0]) != m_mode) nxt = 1;
          m_mode = int'(wr_data[1:0]);
        end else begin
          for (int b = 0; b < 2; b++) begin
            if (wr_addr == 8'(8'h98 + 4 * b)) begin
              rise = wr_data & live_bits(b) & ~m_clk[b];
              if (rise != 0) begin
                if (rdy) begin
                  for (int i = 0; i < 32; i++)
                    if (rise[i]) m_pull[b*32+i] = (m_mode == 3) ? 0 : m_mode;
                end else begin
                  m_err = 1'b1;
                end
              end
              m_clk[b] = wr_data & live_bits(b);
            end
          end
        end
      end
      m_age = nxt;
    end
  end

  function automatic logic [2*NP-1:0] exp_pull();
    logic [2*NP-1:0] v;
    for (int p = 0; p < NP; p++) v[2*p +: 2] = 2'(m_pull[p]);
    return v;
  endfunction

  function automatic logic [31:0] exp_rd();
    case (rd_addr)
      A_MODE:  return 32'(m_mode);
      A_CK0:   return m_clk[0];
      A_CK1:   return m_clk[1];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !done) begin
      check("R4/R8 pull vector", 128'(pull_o), 128'(exp_pull()));
      check("R6/R7 error flag", 128'(err_o), 128'(m_err));
      check("R3/R9 readback", 128'(rd_data), 128'(exp_rd()));
    end
  end

  // ---------------- drivers ----------------
  function automatic logic [7:0] rot_addr(int k);
    case (k % 4)
      0: return A_MODE;
      1: return A_CK0;
      2: return A_CK1;
      default: return 8'h10;
    endcase
  endfunction

  task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = we; wr_addr = a; wr_data = d;
    rd_addr = rot_addr(rot);
    rot++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d);
  endtask

  // let the last write land, then sit at the falling edge with a fixed read address
  task automatic settle(input logic [7:0] ra);
    @(posedge clk); #1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = ra;
    @(negedge clk);
  endtask

  function automatic logic [1:0] pin(int p);
    return pull_o[2*p +: 2];
  endfunction

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // ---------------- directed + random ----------------
  initial begin
    do_reset();
    live = 1'b1;
    settle(A_CK1);
    check("R1 pins after reset", 128'(pull_o), 128'h0);
    check("R1 err after reset", 128'(err_o), 128'h0);
    check("R1 clock bank1 after reset", 128'(rd_data), 128'h0);

    // R4/R2: correct pull-up sequence on pins 0 and 2
    wr(A_MODE, 32'h2);
    idle(SC - 1);
    wr(A_CK0, 32'h5);
    settle(A_MODE);
    check("R4 pin0 pull-up", 128'(pin(0)), 128'h2);
    check("R4 pin1 untouched", 128'(pin(1)), 128'h0);
    check("R4 pin2 pull-up", 128'(pin(2)), 128'h2);
    check("R2 mode readback", 128'(rd_data), 128'h2);
    // R8: clear mode while clock high, then rewrite same clock bits
    wr(A_MODE, 32'h0);
    idle(SC);
    wr(A_CK0, 32'h5);
    settle(A_CK0);
    check("R8 pin0 kept after mode clear", 128'(pin(0)), 128'h2);
    check("R8 no capture on held bits", 128'(err_o), 128'h0);
    wr(A_CK0, 32'h0);

    // R3: pull-down across the partial second bank
    wr(A_MODE, 32'h1);
    idle(SC - 1);
    wr(A_CK1, 32'hFFFF_FFFF);
    settle(A_CK1);
    check("R3 bank1 readback masked", 128'(rd_data), 128'h003F_FFFF);
    check("R3 pin53 pull-down", 128'(pin(53)), 128'h1);
    check("R3 pin31 untouched", 128'(pin(31)), 128'h0);
    wr(A_MODE, 32'h0);
    wr(A_CK1, 32'h0);

    // R5: reserved code clears pin 0
    wr(A_MODE, 32'h3);
    idle(SC - 1);
    wr(A_CK0, 32'h1);
    settle(A_MODE);
    check("R5 code3 gives no pull", 128'(pin(0)), 128'h0);
    check("R2 mode reads 3", 128'(rd_data), 128'h3);
    wr(A_CK0, 32'h0);

    // R6: one cycle short of the setup window
    wr(A_MODE, 32'h2);
    idle(SC - 2);
    wr(A_CK0, 32'h2);
    settle(A_CK0);
    check("R6 early pulse leaves pin1", 128'(pin(1)), 128'h0);
    check("R6 early pulse sets error", 128'(err_o), 128'h1);
    wr(A_CK0, 32'h0);
    // R6: exactly on the threshold
    wr(A_MODE, 32'h1);
    idle(SC - 1);
    wr(A_CK0, 32'h8);
    settle(A_CK0);
    check("R6 threshold pulse captures", 128'(pin(3)), 128'h1);
    check("R7 error stays set", 128'(err_o), 128'h1);
    wr(A_CK0, 32'h0);
    // R6: rewrite of the same value keeps the settled state
    wr(A_MODE, 32'h2);
    idle(SC);
    wr(A_MODE, 32'h2);
    wr(A_CK0, 32'h10);
    settle(A_CK0);
    check("R6 same-value rewrite no restart", 128'(pin(4)), 128'h2);
    wr(A_CK0, 32'h0);

    // R9: unmapped address
    wr(8'h10, 32'hFFFF_FFFF);
    settle(8'h10);
    check("R9 unmapped read zero", 128'(rd_data), 128'h0);
    check("R9 pins unchanged", 128'(pin(4)), 128'h2);

    // R1/R7: reset clears the flag and the pins
    do_reset();
    settle(A_MODE);
    check("R7 reset clears error", 128'(err_o), 128'h0);
    check("R1 pins cleared by reset", 128'(pull_o), 128'h0);

    // random mix checked every cycle by the model
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 11);
      case (r)
        0:       wr(A_MODE, 32'($urandom_range(0, 3)));
        1, 2:    wr(A_CK0, $urandom);
        3:       wr(A_CK1, $urandom);
        4:       wr(A_CK0, 32'h0);
        5:       wr(A_CK1, 32'h0);
        6:       wr(8'h10, $urandom);
        default: idle(1);
      endcase
    end
    settle(A_CK0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule